// File: doc/BRIEF.md
# Soft Mute Ramp with Silence Detector

This block sits in the digital audio path between the serial sample receiver and the interpolation filter. Each time a sample strobe arrives, it scales a left and a right 24-bit two's complement sample by a shared gain and registers the results. The gain is a step counter running from 1024 (unity) down to 0 (silence). While the mute request is high, the gain drops by one step per sample. While the request is low, it climbs back by one step per sample. A full fade in either direction therefore takes 1024 sample periods. Because the counter simply changes direction, a release in the middle of a fade turns the gain around at its present value, with no jump.

A second function counts consecutive strobes on which both input channels are zero. It raises a silence flag once the run reaches 8192 samples. Any nonzero input drops the flag again. The flag looks at the raw input, so muting has no effect on it.

Top module: `smute_zdet`

## Requirements
- R1: After reset, both sample outputs, `valid_o` and `zero_flag_o` are 0, and the gain is unity, so the first unmuted sample passes through unchanged.
- R2: While `mute_i` is high, every strobe lowers the gain by one step until it reaches 0. Starting from unity, the output is zero after 1024 muted samples.
- R3: While `mute_i` is low, every strobe raises the gain by one step until it reaches 1024. Starting from silence, the output equals the input after 1024 unmuted samples.
- R4: If `mute_i` falls before the gain reaches 0, the gain climbs from its current value on the next strobe, with no jump.
- R5: The output for a strobe is (x*g + 512) >>> 10, truncated to 24 bits. Here x is the signed input, g is the gain before this strobe's step, and >>> is an arithmetic shift. It appears on the outputs, with `valid_o` high, one clock after the strobe.
- R6: At gain 1024 the output equals the input bit for bit, including -8388608 and 8388607. At gain 0 the output is exactly 0.
- R7: `zero_flag_o` goes high one clock after the 8192nd consecutive strobe on which both `left_i` and `right_i` are 0, and not before.
- R8: A strobe with a nonzero value on either channel clears the run and drives `zero_flag_o` low one clock later.
- R9: Without a strobe, the gain, the sample outputs and the zero run hold their values, whatever the sample inputs do.
- R10: The zero run is counted on the input samples regardless of `mute_i` or the gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe, one cycle per sample period |
| left_i | input | 24 | Left input sample, two's complement |
| right_i | input | 24 | Right input sample, two's complement |
| mute_i | input | 1 | Mute request, active high |
| valid_o | output | 1 | High one clock after each strobe |
| left_o | output | 24 | Scaled left sample |
| right_o | output | 24 | Scaled right sample |
| zero_flag_o | output | 1 | High after a long run of all-zero input |

## Verification
Every result is due exactly one clock after the strobe edge that captured its sample. This covers the scaled pair, `valid_o` and the silence flag. A gain step made on a strobe shows up only in the output of the following sample. The bench drives each strobe on a falling edge and reads the outputs at the next falling edge. Its reference model applies the gain held before the step to the current sample, and then steps the gain. Every fade and flag boundary is therefore checked at the exact sample where it should take effect.

// File: rtl/smute_pkg.sv
package smute_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/smute_gain_ramp.sv
module smute_gain_ramp
  import smute_pkg::*;
#(
  parameter int STEPS = 1024,
  localparam int GW = $clog2(STEPS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          mute_i,
  output logic [GW-1:0] gain_o
);
  localparam logic [GW-1:0] GMAX = GW'(STEPS);

  logic [GW-1:0] gain_q;
  ramp_dir_e     dir;

  always_comb begin
    dir = RAMP_HOLD;
    if (step_i) begin
      if (mute_i && gain_q != '0)        dir = RAMP_DOWN;
      else if (!mute_i && gain_q != GMAX) dir = RAMP_UP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gain_q <= GMAX;
    else begin
      case (dir)
        RAMP_DOWN: gain_q <= gain_q - GW'(1);
        RAMP_UP:   gain_q <= gain_q + GW'(1);
        default:   gain_q <= gain_q;
      endcase
    end
  end

  assign gain_o = gain_q;

  p_gain_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_q <= GMAX);
  p_mute_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && mute_i && gain_q != '0 |=> gain_q == $past(gain_q) - GW'(1));
  p_release_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !mute_i && gain_q != GMAX |=> gain_q == $past(gain_q) + GW'(1));
  p_gain_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(gain_q));
endmodule

// File: rtl/smute_scaler.sv
module smute_scaler #(
  parameter int DATA_W = 24,
  parameter int STEPS  = 1024,
  localparam int GW    = $clog2(STEPS + 1),
  localparam int SHIFT = $clog2(STEPS),
  localparam int PW    = DATA_W + GW + 1
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic        [GW-1:0]     gain_i,
  output logic signed [DATA_W-1:0] sample_o
);
  localparam logic signed [PW-1:0] HALF = PW'(STEPS / 2);

  logic signed [PW-1:0] x_ext, g_ext, prod, rnd;

  always_comb begin
    x_ext    = $signed({{(GW + 1){sample_i[DATA_W-1]}}, sample_i});
    g_ext    = $signed({{(DATA_W + 1){1'b0}}, gain_i});
    prod     = x_ext * g_ext;
    rnd      = prod + HALF;
    sample_o = DATA_W'(rnd >>> SHIFT);
  end

  initial begin
    a_steps_pow2_r5: assert ((1 << SHIFT) == STEPS);
  end
endmodule

// File: rtl/smute_zero_watch.sv
module smute_zero_watch #(
  parameter int DATA_W = 24,
  parameter int RUN    = 8192,
  localparam int CW    = $clog2(RUN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              flag_o
);
  localparam logic [CW-1:0] RUN_C = CW'(RUN);
  localparam logic [CW-1:0] LAST  = CW'(RUN - 1);

  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic          both_zero;

  assign both_zero = (left_i == '0) && (right_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (step_i) begin
      if (both_zero) begin
        if (cnt_q != RUN_C) cnt_q <= cnt_q + CW'(1);
        flag_q <= (cnt_q >= LAST);
      end else begin
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end
    end
  end

  assign flag_o = flag_q;

  p_flag_full_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> cnt_q == RUN_C);
  p_flag_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && both_zero && cnt_q == LAST |=> flag_q);
  p_nonzero_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !both_zero |=> !flag_q && cnt_q == '0);
  p_run_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q) && $stable(flag_q));
endmodule

// File: rtl/smute_zdet.sv
module smute_zdet #(
  parameter int DATA_W = 24,
  parameter int STEPS  = 1024,
  parameter int RUN    = 8192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic              mute_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              zero_flag_o
);
  localparam int GW    = $clog2(STEPS + 1);
  localparam int NCH   = 2;
  localparam logic [GW-1:0] GMAX = GW'(STEPS);

  logic [GW-1:0]     gain;
  logic [DATA_W-1:0] ch_in  [NCH];
  logic [DATA_W-1:0] ch_out [NCH];
  logic [DATA_W-1:0] ch_q   [NCH];
  logic              valid_q;

  assign ch_in[0] = left_i;
  assign ch_in[1] = right_i;

  smute_gain_ramp #(.STEPS(STEPS)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (valid_i),
    .mute_i (mute_i),
    .gain_o (gain)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [DATA_W-1:0] scaled;

    smute_scaler #(.DATA_W(DATA_W), .STEPS(STEPS)) u_scale (
      .sample_i ($signed(ch_in[c])),
      .gain_i   (gain),
      .sample_o (scaled)
    );

    assign ch_out[c] = scaled;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ch_q[c] <= '0;
      else if (valid_i) ch_q[c] <= ch_out[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  smute_zero_watch #(.DATA_W(DATA_W), .RUN(RUN)) u_zero (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (valid_i),
    .left_i  (left_i),
    .right_i (right_i),
    .flag_o  (zero_flag_o)
  );

  assign valid_o = valid_q;
  assign left_o  = ch_q[0];
  assign right_o = ch_q[1];

  p_unity_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && gain == GMAX |=> left_o == $past(left_i) && right_o == $past(right_i));
  p_full_atten_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && gain == '0 |=> left_o == '0 && right_o == '0);
  p_out_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(left_o) && $stable(right_o));
  p_valid_lag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

// File: tb/smute_zdet_test.sv
module smute_zdet_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic               rst_ni;
  logic               valid_i, mute_i;
  logic signed [23:0] left_i, right_i;
  logic               valid_o, zero_flag_o;
  logic        [23:0] left_o, right_o;

  smute_zdet uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .left_i      (left_i),
    .right_i     (right_i),
    .mute_i      (mute_i),
    .valid_o     (valid_o),
    .left_o      (left_o),
    .right_o     (right_o),
    .zero_flag_o (zero_flag_o)
  );

  // {left, right}; at unity gain the expected output equals the stimulus
  localparam logic [47:0] VEC_TAB [8] = '{
    {24'h000001, 24'hFFFFFF},
    {24'h7FFFFF, 24'h800000},
    {24'h800000, 24'h7FFFFF},
    {24'h123456, 24'hEDCBAA},
    {24'h000000, 24'h000200},
    {24'hFFFE00, 24'h000000},
    {24'h400000, 24'hC00000},
    {24'h0ABCDE, 24'hF54321}
  };

  int checks = 0;
  int fails  = 0;
  int mg     = 1024;
  bit done   = 1'b0;

  function automatic logic signed [23:0] scale_ref(logic signed [23:0] s, int g);
    longint p;
    p = longint'(s) * longint'(g) + 64'sd512;
    return 24'(p >>> 10);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send(input logic signed [23:0] l, input logic signed [23:0] r,
                      input logic m, input string tag);
    logic signed [23:0] el, er;
    el = scale_ref(l, mg);
    er = scale_ref(r, mg);
    if (m && mg > 0) mg--;
    else if (!m && mg < 1024) mg++;
    @(negedge clk);
    valid_i = 1'b1; left_i = l; right_i = r; mute_i = m;
    @(negedge clk);
    valid_i = 1'b0;
    chk(valid_o == 1'b1, {tag, " valid"}, valid_o, 1);
    chk($signed(left_o) == el, {tag, " left"}, $signed(left_o), el);
    chk($signed(right_o) == er, {tag, " right"}, $signed(right_o), er);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; mute_i = 1'b0; left_i = '0; right_i = '0;
    repeat (3) @(negedge clk);
    chk(left_o == '0 && right_o == '0, "R1 reset outputs", left_o, 0);
    chk(valid_o == 1'b0, "R1 reset valid", valid_o, 0);
    chk(zero_flag_o == 1'b0, "R1 reset flag", zero_flag_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk at unity: R5 timing, R6 exact pass-through
    for (int i = 0; i < 8; i++) begin
      send(VEC_TAB[i][47:24], VEC_TAB[i][23:0], 1'b0, "R6 unity table");
      chk(left_o == VEC_TAB[i][47:24], "R6 left exact", left_o, VEC_TAB[i][47:24]);
      chk(right_o == VEC_TAB[i][23:0], "R6 right exact", right_o, VEC_TAB[i][23:0]);
    end

    // R9: inputs move without a strobe
    left_i = 24'sh111111; right_i = -24'sh222222; mute_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(left_o == VEC_TAB[7][47:24], "R9 hold left", left_o, VEC_TAB[7][47:24]);
    chk(right_o == VEC_TAB[7][23:0], "R9 hold right", right_o, VEC_TAB[7][23:0]);
    chk(valid_o == 1'b0, "R9 no valid", valid_o, 0);
    mute_i = 1'b0;
    send(24'sh400000, -24'sh123457, 1'b0, "R9 gain still unity");

    // partial fade, then reverse mid-ramp
    for (int i = 0; i < 300; i++) send(24'sh400000, -24'sh123457, 1'b1, "R2 down ramp");
    chk(mg == 724, "R2 model gain", mg, 724);
    for (int i = 0; i < 100; i++) send(24'sh400000, -24'sh123457, 1'b0, "R4 reversal");

    // full fade to silence
    for (int i = 0; i < 1100; i++) send(24'sh7FFFFF, 24'sh800000, 1'b1, "R2 full mute");
    chk(left_o == '0 && right_o == '0, "R6 zero at full attenuation", left_o, 0);

    // full release back to unity
    for (int i = 0; i < 1024; i++) send(-24'sh3A5A5A, 24'sh05A5A5, 1'b0, "R3 up ramp");
    send(-24'sh3A5A5A, 24'sh05A5A5, 1'b0, "R3 restored");
    chk($signed(left_o) == -24'sh3A5A5A, "R3 unity restored", $signed(left_o), -24'sh3A5A5A);

    // reset mid-fade returns to unity
    for (int i = 0; i < 50; i++) send(24'sh200000, 24'sh200000, 1'b1, "R2 pre-reset");
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    mg = 1024;
    send(24'sh200000, -24'sh000003, 1'b0, "R1 after reset");
    chk(left_o == 24'h200000, "R1 gain unity after reset", left_o, 24'h200000);

    // zero run while muted (R10)
    for (int i = 0; i < 8191; i++) send('0, '0, 1'b1, "R10 zero run");
    chk(zero_flag_o == 1'b0, "R7 flag low at 8191", zero_flag_o, 0);
    send('0, '0, 1'b1, "R10 zero run");
    chk(zero_flag_o == 1'b1, "R7 R10 flag high at 8192", zero_flag_o, 1);
    send('0, 24'sh000005, 1'b0, "R8 right nonzero");
    chk(zero_flag_o == 1'b0, "R8 cleared by right", zero_flag_o, 0);
    for (int i = 0; i < 8192; i++) send('0, '0, 1'b0, "R7 second run");
    chk(zero_flag_o == 1'b1, "R7 flag high again", zero_flag_o, 1);
    repeat (4) @(negedge clk);
    chk(zero_flag_o == 1'b1, "R9 flag holds without strobe", zero_flag_o, 1);
    send(-24'sh000001, '0, 1'b0, "R8 left nonzero");
    chk(zero_flag_o == 1'b0, "R8 cleared by left", zero_flag_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule